// File: doc/BRIEF.md
# EPROM Read Sequencer with Standby Control

This block sits on the host side of a byte-wide, 16K-deep UV EPROM and turns single read requests into correctly timed device cycles. A request carries a 14-bit address. The block drives that address to the device and pulls the chip-select low. It waits until the address has settled, then pulls the output-gate strobe low. Once the gate access time has passed, it captures the byte on the data pins. The byte comes back to the requester with a one-cycle valid pulse.

The chip-select and the output gate are kept apart on purpose. The chip-select decides whether the device is powered up. The output gate only decides whether data appears on the pins. Consecutive reads keep the chip-select low and toggle only the gate. After each read, the block waits for the device outputs to float before it accepts the next request. If no request arrives for a set number of cycles, the block lifts the chip-select so the device drops into low-power standby. A later request pays one full chip-select access time, which is the same latency that a fresh address costs. Every timing value is a parameter counted in clock cycles.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, mem_ce_n and mem_oe_n are 1, req_ready is 1 and rsp_valid is 0.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. From that edge, req_ready stays 0 for exactly ACC_CYC+FLOAT_CYC cycles and then returns to 1.
- R3: mem_addr takes the request address on the accepting edge and holds it for the whole cycle.
- R4: mem_oe_n falls ACC_CYC-OE_CYC cycles after the accepting edge, and mem_ce_n is 0 from the accepting edge onward.
- R5: mem_oe_n stays 0 for OE_CYC cycles. On the edge ACC_CYC cycles after acceptance, mem_oe_n rises and mem_dq is captured. rsp_data then shows the captured byte while rsp_valid is 1 for exactly one cycle.
- R6: After mem_oe_n rises, FLOAT_CYC cycles pass with mem_ce_n low and mem_oe_n high before req_ready returns to 1.
- R7: After req_ready returns to 1, if no request is taken for IDLE_CYC cycles, mem_ce_n goes to 1 on the IDLE_CYC-th edge. mem_oe_n is never 0 while mem_ce_n is 1.
- R8: A request taken before the idle limit expires finds mem_ce_n already 0, and mem_ce_n stays 0 between the two reads.
- R9: A request taken in standby lowers mem_ce_n on the accepting edge and is served with the same ACC_CYC latency.
- R10: req_valid asserted while req_ready is 0 is ignored: mem_addr does not change and no extra response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 14 | Byte address of the request |
| req_ready | output | 1 | Block can take a request this cycle |
| rsp_valid | output | 1 | One-cycle pulse, rsp_data holds the byte |
| rsp_data | output | 8 | Captured byte |
| mem_addr | output | 14 | Address pins of the device |
| mem_ce_n | output | 1 | Device select and power control, active low |
| mem_oe_n | output | 1 | Device output gate, active low |
| mem_dq | input | 8 | Device data pins |

## Verification
All results are timed from the accepting edge k. Below, "k+n" means the value after edge k+n. The gate falls at k+ACC_CYC-OE_CYC. The response and the gate release are seen at k+ACC_CYC. Readiness returns at k+ACC_CYC+FLOAT_CYC. Standby begins IDLE_CYC edges after readiness returns.

The driver checks the device pins and req_ready at the falling edge after each of these edges. The device model in the bench returns the correct byte only when the select time, the address-stable time and the gate time have all been met, so a capture that comes too early is seen as a wrong byte. The scoreboard matches each response against the queued expectation in the cycle the response appears. Any response with no expectation waiting is counted as a failure.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;
  typedef enum logic [2:0] {
    PH_SLEEP  = 3'd0,
    PH_IDLE   = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_FLOAT  = 3'd4
  } phase_t;
endpackage

// File: rtl/eprom_rd_timer.sv
module eprom_rd_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/eprom_rd_idle.sv
module eprom_rd_idle #(
  parameter int LIMIT = 16,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!expire) cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
  import eprom_rd_pkg::*;
#(
  parameter int AW        = 14,
  parameter int ACC_CYC   = 50,
  parameter int OE_CYC    = 30,
  parameter int FLOAT_CYC = 26,
  parameter int IDLE_CYC  = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          take
);
  localparam int SETUP_CYC = ACC_CYC - OE_CYC;
  localparam int TW = $clog2(ACC_CYC + FLOAT_CYC + 1);

  phase_t       phase;
  logic         accept;
  logic         t_load;
  logic [TW-1:0] t_val;
  logic         t_done;
  logic         sleep_now;

  assign accept = req_valid && req_ready;

  eprom_rd_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
  );

  eprom_rd_idle #(.LIMIT(IDLE_CYC)) u_idle (
    .clk(clk), .rst(rst), .run(phase == PH_IDLE && !accept), .expire(sleep_now)
  );

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    take   = 1'b0;
    unique case (phase)
      PH_SLEEP, PH_IDLE: if (accept) begin
        t_load = 1'b1;
        t_val  = TW'(SETUP_CYC - 1);
      end
      PH_SETUP: if (t_done) begin
        t_load = 1'b1;
        t_val  = TW'(OE_CYC - 1);
      end
      PH_STROBE: if (t_done) begin
        t_load = 1'b1;
        t_val  = TW'(FLOAT_CYC - 1);
        take   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_SLEEP;
      req_ready <= 1'b1;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
    end else begin
      unique case (phase)
        PH_SLEEP, PH_IDLE: begin
          if (accept) begin
            phase     <= PH_SETUP;
            req_ready <= 1'b0;
            mem_addr  <= req_addr;
            mem_ce_n  <= 1'b0;
          end else if (sleep_now) begin
            phase    <= PH_SLEEP;
            mem_ce_n <= 1'b1;
          end
        end
        PH_SETUP: if (t_done) begin
          phase    <= PH_STROBE;
          mem_oe_n <= 1'b0;
        end
        PH_STROBE: if (t_done) begin
          phase    <= PH_FLOAT;
          mem_oe_n <= 1'b1;
        end
        PH_FLOAT: if (t_done) begin
          phase     <= PH_IDLE;
          req_ready <= 1'b1;
        end
        default: phase <= PH_SLEEP;
      endcase
    end
  end
endmodule

// File: rtl/eprom_rd_capture.sv
module eprom_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] dq,
  output logic          valid,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= take;
      if (take) data <= dq;
    end
  end
endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl #(
  parameter int AW        = 14,
  parameter int DW        = 8,
  parameter int ACC_CYC   = 50,
  parameter int OE_CYC    = 30,
  parameter int FLOAT_CYC = 26,
  parameter int IDLE_CYC  = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  input  logic [DW-1:0] mem_dq
);
  logic take;

  eprom_rd_seq #(
    .AW(AW), .ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC),
    .FLOAT_CYC(FLOAT_CYC), .IDLE_CYC(IDLE_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .take(take)
  );

  eprom_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .take(take), .dq(mem_dq),
    .valid(rsp_valid), .data(rsp_data)
  );
endmodule

// File: rtl/eprom_rd_chk.sv
module eprom_rd_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n
);
  // R2
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

  // R4
  gate_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> (!mem_ce_n && $past(!mem_ce_n)));

  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R5
  rsp_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (mem_oe_n && !$past(mem_oe_n)));

  // R6
  float_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_ready) |-> (mem_oe_n && $past(mem_oe_n) && !mem_ce_n));

  // R7
  standby_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n |-> mem_oe_n);
endmodule

bind eprom_rd_ctrl eprom_rd_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
  .mem_oe_n(mem_oe_n)
);

// File: tb/sim_eprom_rd_ctrl.sv
module sim_eprom_rd_ctrl;
  localparam int AW = 14, DW = 8;
  localparam int ACC = 6, OE = 3, FLT = 2, IDL = 10;
  localparam int SET = ACC - OE;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n;
  logic [DW-1:0] rsp_data, mem_dq;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0;
  logic [DW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  eprom_rd_ctrl #(.AW(AW), .DW(DW), .ACC_CYC(ACC), .OE_CYC(OE),
                  .FLOAT_CYC(FLT), .IDLE_CYC(IDL)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_dq(mem_dq)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {2'b10, a[13:8]};
  endfunction

  // device model: correct byte only once every access time is met
  logic [AW-1:0] last_a = '0;
  logic last_ce = 1'b1, last_oe = 1'b1;
  int a_cnt = 0, ce_cnt = 0, oe_cnt = 0;
  int a_el, ce_el, oe_el;
  always @(posedge clk) begin
    a_cnt  <= (mem_addr != last_a) ? 1 : a_cnt + 1;
    ce_cnt <= mem_ce_n ? 0 : (last_ce ? 1 : ce_cnt + 1);
    oe_cnt <= mem_oe_n ? 0 : (last_oe ? 1 : oe_cnt + 1);
    last_a <= mem_addr; last_ce <= mem_ce_n; last_oe <= mem_oe_n;
  end
  always_comb begin
    a_el  = (mem_addr != last_a) ? 1 : a_cnt + 1;
    ce_el = mem_ce_n ? 0 : (last_ce ? 1 : ce_cnt + 1);
    oe_el = mem_oe_n ? 0 : (last_oe ? 1 : oe_cnt + 1);
    mem_dq = (a_el >= ACC && ce_el >= ACC && oe_el >= OE) ? pat(mem_addr)
                                                         : ~pat(mem_addr);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor (R5, R10)
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) chk("R10 unexpected response", 32'(rsp_data), 32'hFFFF_FFFF);
      else chk("R5 response data", 32'(rsp_data), 32'(exp_q.pop_front()));
    end
  end

  task automatic do_read(input logic [AW-1:0] a, input logic exp_ce, input bit junk);
    while (!req_ready) @(negedge clk);
    chk(exp_ce ? "R9 standby before request" : "R8 select held while idle",
        32'(mem_ce_n), 32'(exp_ce));
    req_valid = 1'b1; req_addr = a;
    @(posedge clk);
    exp_q.push_back(pat(a));
    for (int j = 0; j <= ACC + FLT; j++) begin
      @(negedge clk);
      if (j == 0) req_valid = 1'b0;
      if (junk && j == 1) begin req_valid = 1'b1; req_addr = ~a; end
      if (junk && j == 4) req_valid = 1'b0;
      chk("R3 address", 32'(mem_addr), 32'(a));
      chk("R4 select low", 32'(mem_ce_n), 0);
      chk("R4 gate timing", 32'(mem_oe_n), 32'(!(j >= SET && j < ACC)));
      chk("R2 ready timing", 32'(req_ready), 32'(j >= ACC + FLT));
      if (j > ACC) chk("R6 float gap gate high", 32'(mem_oe_n), 1);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 select in reset", 32'(mem_ce_n), 1);
        chk("R1 gate in reset", 32'(mem_oe_n), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready", 32'(req_ready), 1);
        chk("R1 no response", 32'(rsp_valid), 0);
        chk("R1 select after reset", 32'(mem_ce_n), 1);
        do_read(14'h0123, 1'b1, 1'b0);          // R9 from standby
        do_read(14'h3FFF, 1'b0, 1'b0);          // R8 back to back
        do_read(14'h0000, 1'b0, 1'b1);          // R10 ignored request
        do_read(14'h2A55, 1'b0, 1'b0);
        for (int m = 1; m <= IDL + 2; m++) begin
          @(negedge clk);
          chk("R7 standby entry", 32'(mem_ce_n), 32'(m >= IDL));
          chk("R7 gate high idle", 32'(mem_oe_n), 1);
        end
        do_read(14'h1C3A, 1'b1, 1'b0);          // R9 exit standby
        repeat (IDL - 2) @(negedge clk);
        do_read(14'h0F0F, 1'b0, 1'b0);          // R8 just before limit
        repeat (3) @(negedge clk);
        chk("R5 all responses seen", 32'(exp_q.size()), 0);
      end
      begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule